// File: doc/BRIEF.md
# Segmented Byte-Fetch Instruction Sequencer

This block is a small instruction sequencer that sits in front of a bus cycle engine. It keeps five 16-bit architectural registers: code segment, instruction pointer, data segment, base register and accumulator. Every bus address it produces is a 20-bit physical address, formed by shifting a segment value left by four bits and adding an offset.

Instructions are fetched one byte per memory read request, and the instruction pointer advances after each byte. After every byte, a decode step decides whether another byte is needed, whether a data write must be issued, or whether the machine stops. Two instructions are recognised:

- A two-byte store (`88h 07h`) writes the low accumulator byte to the data segment at the base register offset.
- A one-byte halt (`F4h`) stops the sequencer.

Any other encoding raises an error flag and halts.

Each bus access is a level request that the engine completes with a one-cycle done pulse, after any number of wait cycles. The register values are taken from input ports while reset is held.

Top module: `seq_fetch_exec`

## Requirements
- R1: A bus address equals (segment × 16 + offset) modulo 2^20. Fetches use the code segment with the instruction pointer. Data writes use the data segment with the base register.
- R2: Every instruction byte is obtained by its own read request (`bus_wr` = 0) at the address built from the current code segment and instruction pointer.
- R3: The instruction pointer increases by exactly 1 when each instruction byte's done pulse is accepted, wrapping from FFFFh to 0000h. It does not change at any other time outside reset.
- R4: First byte 88h followed by second byte 07h causes two reads and then one write request (`bus_wr` = 1). The write carries bits 7:0 of the accumulator and targets the data segment with the base register. After that write completes, the next instruction fetch begins.
- R5: First byte F4h ends the program after that single read. `halted` rises and no further request is issued.
- R6: A first byte other than 88h or F4h sets `error` and `halted` after one read, with the instruction pointer advanced by 1.
- R7: A second byte other than 07h after 88h sets `error` and `halted` after two reads, with the instruction pointer advanced by 2.
- R8: Once raised, `bus_req` stays high with `bus_addr`, `bus_wr` and `bus_wdata` unchanged until the cycle in which `bus_done` is sampled high.
- R9: While `rst_n` is low, `bus_req`, `halted` and `error` are 0. The five registers load from their init ports, so `ip_o` shows `ip_init`.
- R10: `halted` and `error` stay high until the next reset, with no request issued meanwhile.
- R11: The sequence and results do not depend on how many wait cycles pass before each done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| cs_init | input | 16 | Code segment value loaded during reset |
| ip_init | input | 16 | Instruction pointer value loaded during reset |
| ds_init | input | 16 | Data segment value loaded during reset |
| bx_init | input | 16 | Base register value loaded during reset |
| ax_init | input | 16 | Accumulator value loaded during reset |
| bus_req | output | 1 | Bus cycle request, held until done |
| bus_wr | output | 1 | 1 = memory write, 0 = memory read |
| bus_addr | output | 20 | Physical address of the requested cycle |
| bus_wdata | output | 8 | Write data (low accumulator byte) |
| bus_rdata | input | 8 | Read data, valid with `bus_done` |
| bus_done | input | 1 | One-cycle completion of the current request |
| ip_o | output | 16 | Current instruction pointer |
| halted | output | 1 | Sequencer has stopped |
| error | output | 1 | Stop was caused by an unknown encoding |

## Verification
The bench uses the default widths: 16-bit registers and a 4-bit segment shift, giving a 20-bit address space. At this size every one of the 256 first-byte values and every one of the 256 second-byte values after 88h can be swept, with all expected bus traffic computed arithmetically.

Segment and offset pairs near the top of both ranges make the 20-bit address wrap and the 16-bit pointer wrap occur inside a single program. Done latencies cycle from zero to three wait cycles, so request holding is exercised under every pattern.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_STORE_BYTE = 8'h88;
  localparam logic [BYTE_W-1:0] OPC_STOP       = 8'hF4;
  localparam logic [BYTE_W-1:0] MODE_AL_AT_BX  = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_OP,
    ST_DEC_OP,
    ST_FETCH_MODE,
    ST_DEC_MODE,
    ST_EXEC_WR,
    ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    OK_STORE,
    OK_STOP,
    OK_BAD
  } op_kind_t;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/seq_seg_addr.sv
module seq_seg_addr #(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [WORD_W-1:0]           seg_i,
  input  logic [WORD_W-1:0]           ofs_i,
  output logic [WORD_W+SEG_SHIFT-1:0] phys_o
);
  localparam int ADDR_W = WORD_W + SEG_SHIFT;

  logic [ADDR_W-1:0] seg_scaled;
  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    seg_scaled = {seg_i, {SEG_SHIFT{1'b0}}};
    ofs_ext    = {{SEG_SHIFT{1'b0}}, ofs_i};
    phys_o     = seg_scaled + ofs_ext;
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              load_i,
  input  logic              ip_inc_i,
  input  logic [WORD_W-1:0] cs_init,
  input  logic [WORD_W-1:0] ip_init,
  input  logic [WORD_W-1:0] ds_init,
  input  logic [WORD_W-1:0] bx_init,
  input  logic [WORD_W-1:0] ax_init,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] ds_o,
  output logic [WORD_W-1:0] bx_o,
  output logic [WORD_W-1:0] ax_o
);
  logic [WORD_W-1:0] cs_q, ip_q, ds_q, bx_q, ax_q;
  logic [WORD_W-1:0] ip_d;
  logic              ip_en;

  always_comb begin
    ip_en = load_i | ip_inc_i;
    if (load_i) begin
      ip_d = ip_init;
    end else begin
      ip_d = ip_q + WORD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      cs_q <= cs_init;
      ds_q <= ds_init;
      bx_q <= bx_init;
      ax_q <= ax_init;
    end
    if (ip_en) begin
      ip_q <= ip_d;
    end
  end

  assign cs_o = cs_q;
  assign ip_o = ip_q;
  assign ds_o = ds_q;
  assign bx_o = bx_q;
  assign ax_o = ax_q;

  AST_IP_STEP_ONE: assert property (@(posedge clk) disable iff (load_i)
    !$stable(ip_q) |-> (ip_q == $past(ip_q) + WORD_W'(1))); // R3
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  input  logic [BYTE_W-1:0] mode_i,
  output op_kind_t          kind_o,
  output logic              mode_ok_o
);
  always_comb begin
    unique case (op_i)
      OPC_STORE_BYTE: kind_o = OK_STORE;
      OPC_STOP:       kind_o = OK_STOP;
      default:        kind_o = OK_BAD;
    endcase
    mode_ok_o = (mode_i == MODE_AL_AT_BX);
  end
endmodule

// File: rtl/seq_fetch_exec.sv
module seq_fetch_exec
  import seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           cs_init,
  input  logic [WORD_W-1:0]           ip_init,
  input  logic [WORD_W-1:0]           ds_init,
  input  logic [WORD_W-1:0]           bx_init,
  input  logic [WORD_W-1:0]           ax_init,
  output logic                        bus_req,
  output logic                        bus_wr,
  output logic [WORD_W+SEG_SHIFT-1:0] bus_addr,
  output logic [BYTE_W-1:0]           bus_wdata,
  input  logic [BYTE_W-1:0]           bus_rdata,
  input  logic                        bus_done,
  output logic [WORD_W-1:0]           ip_o,
  output logic                        halted,
  output logic                        error
);
  localparam int ADDR_W = WORD_W + SEG_SHIFT;

  logic              rst_sync_n;
  seq_state_t        state_q, state_d;
  logic [BYTE_W-1:0] op_q, mode_q;
  logic              err_q, err_d;
  logic              op_en, mode_en, ip_inc;
  logic [WORD_W-1:0] cs_v, ip_v, ds_v, bx_v, ax_v;
  logic [WORD_W-1:0] seg_sel, ofs_sel;
  logic [ADDR_W-1:0] phys;
  op_kind_t          kind;
  logic              mode_ok;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .load_i   (!rst_sync_n),
    .ip_inc_i (ip_inc),
    .cs_init  (cs_init),
    .ip_init  (ip_init),
    .ds_init  (ds_init),
    .bx_init  (bx_init),
    .ax_init  (ax_init),
    .cs_o     (cs_v),
    .ip_o     (ip_v),
    .ds_o     (ds_v),
    .bx_o     (bx_v),
    .ax_o     (ax_v)
  );

  seq_decode u_dec (
    .op_i      (op_q),
    .mode_i    (mode_q),
    .kind_o    (kind),
    .mode_ok_o (mode_ok)
  );

  always_comb begin
    if (state_q == ST_EXEC_WR) begin
      seg_sel = ds_v;
      ofs_sel = bx_v;
    end else begin
      seg_sel = cs_v;
      ofs_sel = ip_v;
    end
  end

  seq_seg_addr #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
    .seg_i  (seg_sel),
    .ofs_i  (ofs_sel),
    .phys_o (phys)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    op_en   = 1'b0;
    mode_en = 1'b0;
    ip_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: state_d = ST_FETCH_OP;
      ST_FETCH_OP: begin
        if (bus_done) begin
          op_en   = 1'b1;
          ip_inc  = 1'b1;
          state_d = ST_DEC_OP;
        end
      end
      ST_DEC_OP: begin
        unique case (kind)
          OK_STORE: state_d = ST_FETCH_MODE;
          OK_STOP:  state_d = ST_STOP;
          default: begin
            state_d = ST_STOP;
            err_d   = 1'b1;
          end
        endcase
      end
      ST_FETCH_MODE: begin
        if (bus_done) begin
          mode_en = 1'b1;
          ip_inc  = 1'b1;
          state_d = ST_DEC_MODE;
        end
      end
      ST_DEC_MODE: begin
        if (mode_ok) begin
          state_d = ST_EXEC_WR;
        end else begin
          state_d = ST_STOP;
          err_d   = 1'b1;
        end
      end
      ST_EXEC_WR: begin
        if (bus_done) begin
          state_d = ST_FETCH_OP;
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      op_q    <= '0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (op_en) begin
        op_q <= bus_rdata;
      end
      if (mode_en) begin
        mode_q <= bus_rdata;
      end
    end
  end

  assign bus_req   = (state_q == ST_FETCH_OP) || (state_q == ST_FETCH_MODE) ||
                     (state_q == ST_EXEC_WR);
  assign bus_wr    = (state_q == ST_EXEC_WR);
  assign bus_addr  = phys;
  assign bus_wdata = ax_v[BYTE_W-1:0];
  assign ip_o      = ip_v;
  assign halted    = (state_q == ST_STOP);
  assign error     = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) &&
                                $stable(bus_wdata))); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> halted); // R10
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    error |=> error); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |-> !bus_req); // R5
  AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    error |-> halted); // R6
  AST_WRITE_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_wr) |-> $past(ip_v) == ip_v); // R4
endmodule

// File: tb/tb_seq_fetch_exec.sv
`timescale 1ns/1ps
module tb_seq_fetch_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cs_init = '0, ip_init = '0, ds_init = '0, bx_init = '0, ax_init = '0;
  logic        bus_req, bus_wr;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_done = 1'b0;
  logic [15:0] ip_o;
  logic        halted, error;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int wcnt = 0;
  int tx_n = 0;
  int hold_bad = 0;
  int cycles = 0;
  logic        req_seen = 1'b0;
  logic [19:0] first_addr;
  logic        first_wr;
  logic [19:0] tx_addr [8];
  logic        tx_wr   [8];
  logic [7:0]  tx_data [8];
  logic [7:0]  mem [int];

  always #4 clk = ~clk;

  seq_fetch_exec dut (
    .clk(clk), .rst_n(rst_n),
    .cs_init(cs_init), .ip_init(ip_init), .ds_init(ds_init),
    .bx_init(bx_init), .ax_init(ax_init),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .ip_o(ip_o), .halted(halted), .error(error)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] rd(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  // memory responder with programmable wait cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_done = 1'b0; wcnt = 0; req_seen = 1'b0;
    end else if (bus_done) begin
      bus_done = 1'b0; wcnt = 0; req_seen = 1'b0;
    end else if (bus_req) begin
      if (!req_seen) begin
        req_seen = 1'b1; first_addr = bus_addr; first_wr = bus_wr;
      end else if (bus_addr !== first_addr || bus_wr !== first_wr) begin
        hold_bad++;
      end
      if (wcnt >= lat) begin
        if (tx_n < 8) begin
          tx_addr[tx_n] = bus_addr;
          tx_wr[tx_n]   = bus_wr;
          tx_data[tx_n] = bus_wr ? bus_wdata : rd(bus_addr);
        end
        tx_n++;
        if (bus_wr) mem[int'(bus_addr)] = bus_wdata;
        else        bus_rdata = rd(bus_addr);
        bus_done = 1'b1;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_tx(input int k, input logic [19:0] a, input logic w, input logic [7:0] d,
                        input string rq);
    logic [31:0] act, exp;
    act = {3'b0, tx_wr[k], tx_addr[k], tx_data[k]};
    exp = {3'b0, w, a, d};
    chk(act == exp, rq, act, exp);
  endtask

  task automatic run(input logic [15:0] c, input logic [15:0] i, input logic [15:0] d,
                     input logic [15:0] b, input logic [15:0] a, input int l);
    int cyc;
    @(posedge clk); #1;
    rst_n = 1'b0;
    cs_init = c; ip_init = i; ds_init = d; bx_init = b; ax_init = a;
    lat = l; tx_n = 0; hold_bad = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!bus_req && !halted && !error && ip_o == i, "R9 reset state",
        {13'b0, bus_req, halted, error, ip_o}, {16'b0, i});
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 300) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk(halted, "R5 halt reached", {31'b0, halted}, 32'd1);
    repeat (5) @(posedge clk);
    #1;
    chk(halted && !bus_req, "R10 stays halted", {30'b0, halted, bus_req}, 32'd2);
    chk(hold_bad == 0, "R8 request held stable", hold_bad, 0);
  endtask

  task automatic load_prog(input logic [15:0] c, input logic [15:0] i,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    mem.delete();
    mem[int'(phys(c, i))]         = b0;
    mem[int'(phys(c, i + 16'd1))] = b1;
    mem[int'(phys(c, i + 16'd2))] = b2;
  endtask

  // valid store program followed by halt
  task automatic check_full(input logic [15:0] c, input logic [15:0] i, input logic [15:0] d,
                            input logic [15:0] b, input logic [15:0] a);
    chk(tx_n == 4, "R4 cycle count", tx_n, 4);
    chk_tx(0, phys(c, i), 1'b0, 8'h88, "R2 first fetch");
    chk_tx(1, phys(c, i + 16'd1), 1'b0, rd(phys(c, i + 16'd1)), "R1 second fetch");
    chk_tx(2, phys(d, b), 1'b1, a[7:0], "R4 store write");
    chk_tx(3, phys(c, i + 16'd2), 1'b0, 8'hF4, "R1 third fetch");
    chk(ip_o == i + 16'd3 && !error, "R3 final pointer",
        {15'b0, error, ip_o}, {16'b0, i + 16'd3});
  endtask

  initial begin
    int idx;
    logic [15:0] c, i, d, b, a;
    idx = 0;

    // directed vector
    load_prog(16'h1000, 16'h0005, 8'h88, 8'h07, 8'hF4);
    run(16'h1000, 16'h0005, 16'h2000, 16'h0023, 16'h351C, 0);
    chk(tx_addr[0] == 20'h10005 && tx_addr[2] == 20'h20023 && tx_data[2] == 8'h1C,
        "R4 directed vector", {tx_addr[2], tx_data[2]}, {20'h20023, 8'h1C});
    check_full(16'h1000, 16'h0005, 16'h2000, 16'h0023, 16'h351C);

    // sweep every first byte
    for (int v = 0; v < 256; v++) begin
      c = 16'h1000 + 16'(v); i = 16'(v * 7); d = 16'h3000 + 16'(v);
      b = 16'(v * 13); a = {8'(v) ^ 8'h5A, ~8'(v)};
      load_prog(c, i, 8'(v), 8'h07, 8'hF4);
      run(c, i, d, b, a, idx % 4);
      idx++;
      if (v == 8'h88) begin
        check_full(c, i, d, b, a);
      end else if (v == 8'hF4) begin
        chk(tx_n == 1 && !error && ip_o == i + 16'd1, "R5 single fetch halt",
            {tx_n[14:0], error, ip_o}, {15'd1, 1'b0, i + 16'd1});
        chk_tx(0, phys(c, i), 1'b0, 8'hF4, "R5 halt fetch");
      end else begin
        chk(tx_n == 1 && error && ip_o == i + 16'd1, "R6 bad first byte",
            {tx_n[14:0], error, ip_o}, {15'd1, 1'b1, i + 16'd1});
        chk_tx(0, phys(c, i), 1'b0, 8'(v), "R11 fetch under wait cycles");
      end
    end

    // sweep every second byte after the store opcode
    for (int v = 0; v < 256; v++) begin
      c = 16'h1100 + 16'(v); i = 16'(v * 5); d = 16'h3400 + 16'(v);
      b = 16'(v * 11); a = {~8'(v), 8'(v)};
      load_prog(c, i, 8'h88, 8'(v), 8'hF4);
      run(c, i, d, b, a, idx % 4);
      idx++;
      if (v == 8'h07) begin
        check_full(c, i, d, b, a);
      end else begin
        chk(tx_n == 2 && error && ip_o == i + 16'd2, "R7 bad second byte",
            {tx_n[14:0], error, ip_o}, {15'd2, 1'b1, i + 16'd2});
        chk_tx(1, phys(c, i + 16'd1), 1'b0, 8'(v), "R7 second fetch");
      end
    end

    // address and pointer wrap region; low byte of accumulator is F4 so any overlap is harmless
    for (int k = 0; k < 16; k++) begin
      c = 16'hF000 + 16'(k * 16'h0111); i = 16'hFFFD + 16'(k);
      d = 16'h0040 + 16'(k * 16'h0100); b = 16'hFFF8 + 16'(k);
      a = {8'(k * 17), 8'hF4};
      load_prog(c, i, 8'h88, 8'h07, 8'hF4);
      run(c, i, d, b, a, k % 4);
      check_full(c, i, d, b, a);
    end

    // explicit top-of-range case
    load_prog(16'hFFFF, 16'hFFFE, 8'h88, 8'h07, 8'hF4);
    run(16'hFFFF, 16'hFFFE, 16'hFFFF, 16'h0020, 16'h12F4, 3);
    chk(tx_addr[0] == 20'h0FFEE && tx_addr[2] == 20'h00010 && tx_addr[3] == 20'hFFFF0,
        "R1 address wrap", {12'b0, tx_addr[3]}, {12'b0, 20'hFFFF0});
    chk(ip_o == 16'h0001, "R3 pointer wrap", ip_o, 16'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule